// File: doc/BRIEF.md
# Co-processor I/O Register File

This block sits on the byte bus of an audio co-processor and gives the sixteen bytes at 0x00F0–0x00FF their register meaning. It holds a control byte and an indirect selector/data pair that reaches the 128 registers of an external DSP core. It keeps four host mailbox ports, each with an inbound latch written by the host and an outbound latch written by the CPU. It also holds two scratch bytes and decodes strobes for three external timers. It also lays a 64-byte boot ROM over the top of the address space while the overlay bit is set.

The 64 KiB RAM is outside the block. Every CPU write is passed to it unchanged, including writes into the register window and the ROM area. CPU reads are answered combinationally in the same cycle. The answer comes from the register window, from the ROM overlay, or from the RAM read data, in that order of precedence. Register writes take effect at the clock edge that samples `cpu_we`. The timers read the new target value from `ram_wdata` in the cycle that `tmr_tgt_we` is high.

Top module: `iorf_regfile`

## Requirements
- R1: After reset, `tmr_en` is 0, the ROM overlay is on, and these all read 0: the DSP selector, both scratch bytes, all inbound latches and all outbound latches.
- R2: Every CPU write drives `ram_we` high in the same cycle, with `ram_addr` and `ram_wdata` equal to the CPU address and data. This holds inside the register window and the ROM area too.
- R3: While control bit 7 is 1, reads of 0xFFC0+i (i = 0..63) return (i*37 + 0x5A) mod 256. While it is 0, those reads return `ram_rdata`. Writes there still go to RAM.
- R4: A write to 0x00F1 sets `tmr_en` to data bits 2..0 and the overlay enable to data bit 7, from the next cycle on.
- R5: A write to 0x00F1 with bit 4 set clears the inbound latches of ports 0 and 1. Bit 5 does the same for ports 2 and 3. A host write to a latch in the same cycle as its clear is lost.
- R6: `dsp_addr` is the low 7 bits of the selector at 0x00F2. A CPU write to 0x00F3 pulses `dsp_we` with the CPU data only when the selector is 0x7F or less. Otherwise no DSP write occurs.
- R7: A read of 0x00F3 returns `dsp_rdata`. A read of 0x00F2 returns the full stored selector.
- R8: A CPU read of 0x00F4+k returns inbound latch k, which the host writes through `host_port`=k. A CPU write to 0x00F4+k sets outbound latch k, seen on `host_rdata` while `host_port`=k.
- R9: 0x00F8 and 0x00F9 read back the last byte written to them.
- R10: A write to 0x00FA+k pulses `tmr_tgt_we[k]`. A read of 0x00FD+k returns {0000, `tmr_cnt[k]`} and pulses `tmr_cnt_rd[k]`. Reads of 0x00F0, 0x00F1 and 0x00FA–0x00FC return 0.
- R11: Reads outside the window and outside an active overlay return `ram_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU byte address |
| cpu_we | input | 1 | CPU write strobe |
| cpu_re | input | 1 | CPU read strobe |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | CPU read data (combinational) |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | 16 | RAM address |
| ram_wdata | output | 8 | RAM write data, also timer target data |
| ram_rdata | input | 8 | RAM read data |
| dsp_addr | output | 7 | DSP register index |
| dsp_we | output | 1 | DSP register write strobe |
| dsp_wdata | output | 8 | DSP register write data |
| dsp_rdata | input | 8 | DSP register read data |
| host_port | input | 2 | Host-side port index |
| host_we | input | 1 | Host write to an inbound latch |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Outbound latch of the selected port |
| tmr_en | output | 3 | Timer enables |
| tmr_tgt_we | output | 3 | Timer target write strobes |
| tmr_cnt_rd | output | 3 | Timer counter read strobes |
| tmr_cnt | input | 3x4 | Timer counter values |

## Verification
The embedded properties check several relations on every cycle:
- a clear of a port pair empties both inbound latches on the next edge, even when the host writes at the same time;
- each CPU port write appears in its outbound latch one cycle later;
- a control write sets the timer enables on the next cycle;
- every DSP write strobe traces back to a CPU write of 0x00F3 carrying the same data;
- the timer strobes are never more than one-hot.

Some behaviour only the bench scenarios can show:
- the ROM contents and the switch of the overlay between ROM and RAM data;
- the refusal of a DSP write when the selector is above 0x7F;
- the fact that a port read returns the host's byte and not the CPU's;
- the reset values of the register window.

// File: rtl/iorf_pkg.sv
package iorf_pkg;

    localparam int DATA_W     = 8;
    localparam int ADDR_W     = 16;
    localparam int NUM_PORTS  = 4;
    localparam int NUM_TIMERS = 3;
    localparam int CNT_W      = 4;
    localparam int ROM_BYTES  = 64;
    localparam int ROM_AW     = $clog2(ROM_BYTES);
    localparam int SLOT_W     = 4;
    localparam int PORT_AW    = $clog2(NUM_PORTS);
    localparam int DSP_AW     = 7;

    localparam logic [ADDR_W-SLOT_W-1:0] WIN_TAG = 12'h00F;
    localparam logic [ADDR_W-ROM_AW-1:0] ROM_TAG = {(ADDR_W-ROM_AW){1'b1}};

    // Control byte bit positions (software-visible encoding)
    localparam int CTL_CLR_LO = 4;
    localparam int CTL_CLR_HI = 5;
    localparam int CTL_ROM    = 7;

    typedef enum logic [SLOT_W-1:0] {
        SLOT_TEST  = 4'h0,
        SLOT_CTRL  = 4'h1,
        SLOT_DSEL  = 4'h2,
        SLOT_DDATA = 4'h3,
        SLOT_PORT0 = 4'h4,
        SLOT_PORT1 = 4'h5,
        SLOT_PORT2 = 4'h6,
        SLOT_PORT3 = 4'h7,
        SLOT_SCR0  = 4'h8,
        SLOT_SCR1  = 4'h9,
        SLOT_TGT0  = 4'hA,
        SLOT_TGT1  = 4'hB,
        SLOT_TGT2  = 4'hC,
        SLOT_CNT0  = 4'hD,
        SLOT_CNT1  = 4'hE,
        SLOT_CNT2  = 4'hF
    } slot_e;

    // Fields decoded from a control-byte write
    typedef struct packed {
        logic                  rom_on;
        logic                  clr_hi;
        logic                  clr_lo;
        logic [NUM_TIMERS-1:0] tmr_en;
    } ctl_wr_t;

    // Persistent part of the control byte
    typedef struct packed {
        logic                  rom_on;
        logic [NUM_TIMERS-1:0] tmr_en;
    } ctl_state_t;

    localparam ctl_state_t CTL_RESET = '{rom_on: 1'b1, tmr_en: '0};

    function automatic logic [DATA_W-1:0] rom_byte(input logic [ROM_AW-1:0] idx);
        logic [DATA_W-1:0] prod;
        prod = DATA_W'(idx) * 8'd37;
        return prod + 8'h5A;
    endfunction

endpackage

// File: rtl/iorf_decode.sv
module iorf_decode
    import iorf_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output logic              in_win,
    output logic              in_rom,
    output logic [SLOT_W-1:0] slot
);
    assign in_win = (addr[ADDR_W-1:SLOT_W] == WIN_TAG);
    assign in_rom = (addr[ADDR_W-1:ROM_AW] == ROM_TAG);
    assign slot   = addr[SLOT_W-1:0];
endmodule

// File: rtl/iorf_ctrl.sv
module iorf_ctrl
    import iorf_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  ctl_wr_t               wr,
    output logic [NUM_TIMERS-1:0] tmr_en,
    output logic                  rom_on,
    output logic [1:0]            clr_pair
);
    ctl_state_t state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= CTL_RESET;
        end else if (wr_en) begin
            state_q.rom_on <= wr.rom_on;
            state_q.tmr_en <= wr.tmr_en;
        end
    end

    assign tmr_en   = state_q.tmr_en;
    assign rom_on   = state_q.rom_on;
    assign clr_pair = wr_en ? {wr.clr_hi, wr.clr_lo} : 2'b00;

    a_r4_tmr_en: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (tmr_en == $past(wr.tmr_en) && rom_on == $past(wr.rom_on)));
endmodule

// File: rtl/iorf_mailbox.sv
module iorf_mailbox
    import iorf_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst,
    input  logic [NUM_PORTS-1:0]              cpu_port_we,
    input  logic [DATA_W-1:0]                 cpu_wdata,
    input  logic                              host_we,
    input  logic [PORT_AW-1:0]                host_port,
    input  logic [DATA_W-1:0]                 host_wdata,
    input  logic [1:0]                        clr_pair,
    output logic [NUM_PORTS-1:0][DATA_W-1:0]  in_q,
    output logic [NUM_PORTS-1:0][DATA_W-1:0]  out_q
);
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        logic host_hit;
        assign host_hit = host_we && (host_port == PORT_AW'(p));

        always_ff @(posedge clk) begin
            if (rst) begin
                in_q[p] <= '0;
            end else if (clr_pair[p/2]) begin
                in_q[p] <= '0;
            end else if (host_hit) begin
                in_q[p] <= host_wdata;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                out_q[p] <= '0;
            end else if (cpu_port_we[p]) begin
                out_q[p] <= cpu_wdata;
            end
        end

        a_r8_out_latch: assert property (@(posedge clk) disable iff (rst)
            cpu_port_we[p] |=> (out_q[p] == $past(cpu_wdata)));

        a_r5_clear_wins: assert property (@(posedge clk) disable iff (rst)
            clr_pair[p/2] |=> (in_q[p] == '0));
    end
endmodule

// File: rtl/iorf_dsp_link.sv
module iorf_dsp_link
    import iorf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_we,
    input  logic              data_we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] sel_q,
    output logic [DSP_AW-1:0] dsp_addr,
    output logic              dsp_we,
    output logic [DATA_W-1:0] dsp_wdata
);
    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= '0;
        end else if (sel_we) begin
            sel_q <= wdata;
        end
    end

    assign dsp_addr  = sel_q[DSP_AW-1:0];
    assign dsp_we    = data_we && !sel_q[DATA_W-1];
    assign dsp_wdata = wdata;
endmodule

// File: rtl/iorf_regfile.sv
module iorf_regfile
    import iorf_pkg::*;
(
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic [ADDR_W-1:0]                    cpu_addr,
    input  logic                                 cpu_we,
    input  logic                                 cpu_re,
    input  logic [DATA_W-1:0]                    cpu_wdata,
    output logic [DATA_W-1:0]                    cpu_rdata,
    output logic                                 ram_we,
    output logic [ADDR_W-1:0]                    ram_addr,
    output logic [DATA_W-1:0]                    ram_wdata,
    input  logic [DATA_W-1:0]                    ram_rdata,
    output logic [DSP_AW-1:0]                    dsp_addr,
    output logic                                 dsp_we,
    output logic [DATA_W-1:0]                    dsp_wdata,
    input  logic [DATA_W-1:0]                    dsp_rdata,
    input  logic [PORT_AW-1:0]                   host_port,
    input  logic                                 host_we,
    input  logic [DATA_W-1:0]                    host_wdata,
    output logic [DATA_W-1:0]                    host_rdata,
    output logic [NUM_TIMERS-1:0]                tmr_en,
    output logic [NUM_TIMERS-1:0]                tmr_tgt_we,
    output logic [NUM_TIMERS-1:0]                tmr_cnt_rd,
    input  logic [NUM_TIMERS-1:0][CNT_W-1:0]     tmr_cnt
);
    logic              in_win, in_rom, rom_on;
    logic [SLOT_W-1:0] slot;
    logic              win_we, win_re;
    logic [1:0]        clr_pair;
    logic [DATA_W-1:0] dsel_q;
    logic [NUM_PORTS-1:0]             port_we;
    logic [NUM_PORTS-1:0][DATA_W-1:0] in_q, out_q;
    logic [1:0][DATA_W-1:0]           scr_q;
    ctl_wr_t           ctl_wr;

    iorf_decode u_dec (.addr(cpu_addr), .in_win(in_win), .in_rom(in_rom), .slot(slot));

    assign win_we = cpu_we && in_win;
    assign win_re = cpu_re && in_win;

    // RAM underneath always sees the write
    assign ram_we    = cpu_we;
    assign ram_addr  = cpu_addr;
    assign ram_wdata = cpu_wdata;

    assign ctl_wr = '{rom_on: cpu_wdata[CTL_ROM],
                      clr_hi: cpu_wdata[CTL_CLR_HI],
                      clr_lo: cpu_wdata[CTL_CLR_LO],
                      tmr_en: cpu_wdata[NUM_TIMERS-1:0]};

    iorf_ctrl u_ctrl (
        .clk(clk), .rst(rst),
        .wr_en(win_we && slot == SLOT_CTRL), .wr(ctl_wr),
        .tmr_en(tmr_en), .rom_on(rom_on), .clr_pair(clr_pair)
    );

    iorf_dsp_link u_dsp (
        .clk(clk), .rst(rst),
        .sel_we(win_we && slot == SLOT_DSEL),
        .data_we(win_we && slot == SLOT_DDATA),
        .wdata(cpu_wdata), .sel_q(dsel_q),
        .dsp_addr(dsp_addr), .dsp_we(dsp_we), .dsp_wdata(dsp_wdata)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_pwe
        assign port_we[p] = win_we && (slot == SLOT_W'(int'(SLOT_PORT0) + p));
    end

    iorf_mailbox u_mbx (
        .clk(clk), .rst(rst),
        .cpu_port_we(port_we), .cpu_wdata(cpu_wdata),
        .host_we(host_we), .host_port(host_port), .host_wdata(host_wdata),
        .clr_pair(clr_pair), .in_q(in_q), .out_q(out_q)
    );

    assign host_rdata = out_q[host_port];

    for (genvar s = 0; s < 2; s++) begin : g_scr
        always_ff @(posedge clk) begin
            if (rst) begin
                scr_q[s] <= '0;
            end else if (win_we && slot == SLOT_W'(int'(SLOT_SCR0) + s)) begin
                scr_q[s] <= cpu_wdata;
            end
        end
    end

    for (genvar t = 0; t < NUM_TIMERS; t++) begin : g_tmr
        assign tmr_tgt_we[t] = win_we && (slot == SLOT_W'(int'(SLOT_TGT0) + t));
        assign tmr_cnt_rd[t] = win_re && (slot == SLOT_W'(int'(SLOT_CNT0) + t));
    end

    always_comb begin
        cpu_rdata = ram_rdata;
        if (in_rom && rom_on) begin
            cpu_rdata = rom_byte(cpu_addr[ROM_AW-1:0]);
        end
        if (in_win) begin
            unique case (slot_e'(slot))
                SLOT_DSEL:  cpu_rdata = dsel_q;
                SLOT_DDATA: cpu_rdata = dsp_rdata;
                SLOT_PORT0: cpu_rdata = in_q[0];
                SLOT_PORT1: cpu_rdata = in_q[1];
                SLOT_PORT2: cpu_rdata = in_q[2];
                SLOT_PORT3: cpu_rdata = in_q[3];
                SLOT_SCR0:  cpu_rdata = scr_q[0];
                SLOT_SCR1:  cpu_rdata = scr_q[1];
                SLOT_CNT0:  cpu_rdata = DATA_W'(tmr_cnt[0]);
                SLOT_CNT1:  cpu_rdata = DATA_W'(tmr_cnt[1]);
                SLOT_CNT2:  cpu_rdata = DATA_W'(tmr_cnt[2]);
                default:    cpu_rdata = '0;
            endcase
        end
    end

    a_r6_dsp_source: assert property (@(posedge clk) disable iff (rst)
        dsp_we |-> (cpu_we && cpu_addr == 16'h00F3 && dsp_wdata == cpu_wdata));

    a_r10_strobe_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(tmr_cnt_rd) && $onehot0(tmr_tgt_we));
endmodule

// File: tb/iorf_regfile_bench.sv
module iorf_regfile_bench;
    logic        clk = 0;
    logic        rst = 1;
    logic [15:0] cpu_addr = '0;
    logic        cpu_we = 0, cpu_re = 0;
    logic [7:0]  cpu_wdata = '0;
    logic [7:0]  cpu_rdata;
    logic        ram_we;
    logic [15:0] ram_addr;
    logic [7:0]  ram_wdata, ram_rdata;
    logic [6:0]  dsp_addr;
    logic        dsp_we;
    logic [7:0]  dsp_wdata;
    logic [7:0]  dsp_rdata = '0;
    logic [1:0]  host_port = '0;
    logic        host_we = 0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic [2:0]  tmr_en, tmr_tgt_we, tmr_cnt_rd;
    logic [2:0][3:0] tmr_cnt = '0;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    // RAM model: data is a fixed function of the address
    assign ram_rdata = cpu_addr[15:8] ^ cpu_addr[7:0] ^ 8'hC3;

    iorf_regfile u_iorf_regfile (
        .clk(clk), .rst(rst),
        .cpu_addr(cpu_addr), .cpu_we(cpu_we), .cpu_re(cpu_re),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
        .dsp_addr(dsp_addr), .dsp_we(dsp_we), .dsp_wdata(dsp_wdata), .dsp_rdata(dsp_rdata),
        .host_port(host_port), .host_we(host_we), .host_wdata(host_wdata),
        .host_rdata(host_rdata),
        .tmr_en(tmr_en), .tmr_tgt_we(tmr_tgt_we), .tmr_cnt_rd(tmr_cnt_rd), .tmr_cnt(tmr_cnt)
    );

    function automatic logic [7:0] exp_rom(input int i);
        return 8'((i * 37 + 'h5A) % 256);
    endfunction

    task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic put_wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_we = 1; cpu_re = 0;
        #1;
    endtask

    task automatic put_rd(input logic [15:0] a);
        @(negedge clk);
        cpu_addr = a; cpu_we = 0; cpu_re = 1;
        #1;
    endtask

    task automatic release_bus();
        @(posedge clk);
        #1;
        cpu_we = 0; cpu_re = 0;
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        put_wr(a, d);
        release_bus();
    endtask

    task automatic rd_chk(input logic [15:0] a, input logic [7:0] e, input string req);
        put_rd(a);
        chk(16'(cpu_rdata), 16'(e), req);
        release_bus();
    endtask

    task automatic host_wr(input logic [1:0] p, input logic [7:0] d);
        @(negedge clk);
        host_port = p; host_wdata = d; host_we = 1;
        @(posedge clk);
        #1;
        host_we = 0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // op(2) addr(16) data(8) expect(8); op 0 = write, 1 = read and compare
    localparam logic [33:0] VEC [14] = '{
        {2'd0, 16'h00F8, 8'hA5, 8'h00},   // R9
        {2'd0, 16'h00F9, 8'h3C, 8'h00},   // R9
        {2'd1, 16'h00F8, 8'h00, 8'hA5},   // R9
        {2'd1, 16'h00F9, 8'h00, 8'h3C},   // R9
        {2'd0, 16'h00F2, 8'h15, 8'h00},   // R7
        {2'd1, 16'h00F2, 8'h00, 8'h15},   // R7
        {2'd0, 16'h00F4, 8'h11, 8'h00},   // R8 write goes out, not in
        {2'd1, 16'h00F4, 8'h00, 8'h00},   // R8
        {2'd1, 16'h1234, 8'h00, 8'hE5},   // R11
        {2'd0, 16'h00F1, 8'h00, 8'h00},   // R3 overlay off
        {2'd1, 16'hFFC5, 8'h00, 8'hF9},   // R3 RAM visible
        {2'd0, 16'h00F1, 8'h80, 8'h00},   // R3 overlay on
        {2'd1, 16'hFFC5, 8'h00, 8'h13},   // R3 ROM byte 5
        {2'd1, 16'h00F1, 8'h00, 8'h00}    // R10 control reads 0
    };

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;

        // R1 reset state
        #1;
        chk(16'(tmr_en), 16'h0, "R1");
        for (int p = 0; p < 4; p++) begin
            host_port = 2'(p);
            #1;
            chk(16'(host_rdata), 16'h0, "R1");
        end
        rd_chk(16'h00F2, 8'h00, "R1");
        rd_chk(16'h00F8, 8'h00, "R1");
        rd_chk(16'h00F9, 8'h00, "R1");
        rd_chk(16'h00F5, 8'h00, "R1");
        rd_chk(16'hFFC0, exp_rom(0), "R1");

        // Vector table
        for (int i = 0; i < 14; i++) begin
            if (VEC[i][33:32] == 2'd0)
                wr(VEC[i][31:16], VEC[i][15:8]);
            else
                rd_chk(VEC[i][31:16], VEC[i][7:0], "R3/R7/R8/R9/R10/R11 table");
        end

        // R4 timer enables and overlay bit
        wr(16'h00F1, 8'h85);
        chk(16'(tmr_en), 16'h5, "R4");
        rd_chk(16'hFFC1, exp_rom(1), "R4");

        // R8 outbound and inbound latches are separate
        wr(16'h00F5, 8'h77);
        host_port = 2'd1; #1;
        chk(16'(host_rdata), 16'h77, "R8");
        rd_chk(16'h00F5, 8'h00, "R8");
        host_wr(2'd2, 8'h99);
        rd_chk(16'h00F6, 8'h99, "R8");

        // R5 clears and priority over a host write
        host_wr(2'd0, 8'h44);
        host_wr(2'd3, 8'h55);
        @(negedge clk);
        cpu_addr = 16'h00F1; cpu_wdata = 8'h90; cpu_we = 1;
        host_port = 2'd1; host_wdata = 8'h66; host_we = 1;
        @(posedge clk); #1;
        cpu_we = 0; host_we = 0;
        rd_chk(16'h00F4, 8'h00, "R5");
        rd_chk(16'h00F5, 8'h00, "R5");
        rd_chk(16'h00F7, 8'h55, "R5");
        rd_chk(16'h00F6, 8'h99, "R5");
        wr(16'h00F1, 8'hA0);
        rd_chk(16'h00F7, 8'h00, "R5");
        rd_chk(16'h00F6, 8'h00, "R5");

        // R6 DSP write gating
        wr(16'h00F2, 8'h7F);
        put_wr(16'h00F3, 8'h21);
        chk(16'(dsp_we), 16'h1, "R6");
        chk(16'(dsp_addr), 16'h7F, "R6");
        chk(16'(dsp_wdata), 16'h21, "R6");
        release_bus();
        wr(16'h00F2, 8'h80);
        put_wr(16'h00F3, 8'h22);
        chk(16'(dsp_we), 16'h0, "R6");
        release_bus();

        // R7 DSP read
        wr(16'h00F2, 8'h85);
        dsp_rdata = 8'hBE;
        put_rd(16'h00F3);
        chk(16'(cpu_rdata), 16'hBE, "R7");
        chk(16'(dsp_addr), 16'h05, "R7");
        release_bus();
        rd_chk(16'h00F2, 8'h85, "R7");

        // R10 timer strobes
        tmr_cnt = {4'h9, 4'h6, 4'h3};
        put_rd(16'h00FE);
        chk(16'(cpu_rdata), 16'h06, "R10");
        chk(16'(tmr_cnt_rd), 16'b010, "R10");
        release_bus();
        rd_chk(16'h00FF, 8'h09, "R10");
        put_wr(16'h00FB, 8'h40);
        chk(16'(tmr_tgt_we), 16'b010, "R10");
        release_bus();
        rd_chk(16'h00FB, 8'h00, "R10");

        // R2 writes reach RAM even under the ROM overlay
        wr(16'h00F1, 8'h80);
        put_wr(16'hFFC3, 8'hD2);
        chk(16'(ram_we), 16'h1, "R2");
        chk(ram_addr, 16'hFFC3, "R2");
        chk(16'(ram_wdata), 16'hD2, "R2");
        release_bus();
        rd_chk(16'hFFC3, exp_rom(3), "R3");
        put_wr(16'h00F8, 8'h5E);
        chk(16'(ram_we), 16'h1, "R2");
        chk(ram_addr, 16'h00F8, "R2");
        release_bus();

        finish_run();
    end
endmodule